// File: doc/BRIEF.md
# Vector Block Context Status Register

This block keeps the 32-bit context word that a processor consults while it runs a prefixed block of scalar instructions that are to be executed as vectors. A small four-state machine sits behind the word, and the state code appears directly in the top two bits of the register. The machine moves from normal scalar execution to header captured. From there it moves to length setup actioned, meaning tables are being loaded. Its last state is tables loaded. The machine advances on a header strobe from fetch, a vector-length setup completion pulse and a table-load completion pulse. A trap taken once the tables are loaded sends the state back to the loading phase, so that the tables are read again. A block-exit pulse clears everything.

Software reaches the word through a CSR write port that has two forms. A register-form write loads the whole word as it is, for context restore. An immediate-form write targets only the 5-bit offset pointer. It is accepted only in the tables-loaded state, and only for an offset strictly below the block-length limit input. An accepted write requests a jump inside the block. Every other immediate-form write raises an illegal-instruction flag. Both flags are one-cycle registered pulses.

Top module: `vbc_top`

## Requirements
- R1: While reset is asserted and after it is released, the context word is zero and jump_req and illegal are low.
- R2: The context word layout is: status in bits 31:30 (0 scalar, 1 header captured, 2 tables loading, 3 tables loaded), vlset in 29, ilen in 28:26, plen in 25:24, rlen in 23:22, mode in 21, second header in 20:5 and offset pointer in 4:0. With status 0 and hdr_valid high, the next edge sets status 1 and copies vlset=hdr_word[0], ilen=hdr_word[3:1], plen=hdr_word[5:4], rlen=hdr_word[7:6] and mode=hdr_word[8]. The same edge clears the offset pointer. hdr_valid has no effect in any other status.
- R3: At header capture, the second-header field takes hdr_word[31:16] only when hdr_word[3:1] is 3'b111; otherwise it becomes zero.
- R4: vl_done moves status 1 to 2, and tbl_done moves status 2 to 3. Each pulse has no effect in any other status.
- R5: trap in status 3 moves status to 2 and leaves all other fields unchanged; trap in any other status has no effect.
- R6: An immediate-form write in status 3 whose 5-bit value v satisfies v < blk_limit stores v in the offset pointer. On the next cycle jump_req is high for one cycle, and jump_ofs equals v.
- R7: An immediate-form write with status other than 3, or with v >= blk_limit, leaves the word unchanged and pulses illegal for one cycle. jump_req and illegal are never high together.
- R8: A register-form write loads all 32 bits of csr_wdata, status included, on the next edge. It raises neither jump_req nor illegal.
- R9: blk_exit clears the whole word and suppresses both flags on the next edge. It takes priority over every other input.
- R10: A register-form write takes priority over hdr_valid, vl_done, tbl_done and trap in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header word on hdr_word is valid |
| hdr_word | input | 32 | Header word from the fetch stream |
| vl_done | input | 1 | Vector-length setup actioned |
| tbl_done | input | 1 | Predicate and register tables loaded |
| trap | input | 1 | Trap taken |
| blk_exit | input | 1 | Leave the vector block |
| csr_we | input | 1 | CSR write strobe |
| csr_imm | input | 1 | 1 = immediate-form write, 0 = register-form write |
| csr_wdata | input | 32 | CSR write data (bits 4:0 are the immediate) |
| blk_limit | input | 6 | Block length; offsets below it are in range |
| ctx_reg | output | 32 | Packed context word |
| jump_req | output | 1 | One-cycle jump request |
| jump_ofs | output | 5 | Jump target offset |
| illegal | output | 1 | One-cycle illegal-instruction flag |

## Verification
The bench builds the block with its defaults: a 5-bit offset and a 16-bit second header. With these values every immediate offset from 0 to 31 is reachable. blk_limit can be driven over its full range, from 0, where every write is rejected, to 32, where every write is accepted. This also reaches the edge pair v = limit-1 (accepted) and v = limit (rejected).

// File: rtl/vbc_pkg.sv
package vbc_pkg;

  typedef enum logic [1:0] {
    ST_SCALAR = 2'd0,
    ST_HDR    = 2'd1,
    ST_TBL    = 2'd2,
    ST_READY  = 2'd3
  } vbc_status_e;

  localparam int unsigned ST_W    = 2;
  localparam int unsigned ILEN_W  = 3;
  localparam int unsigned PLEN_W  = 2;
  localparam int unsigned RLEN_W  = 2;
  localparam int unsigned HDR1_W  = 16;
  localparam logic [ILEN_W-1:0] ILEN_EXT = 3'b111;

endpackage

// File: rtl/vbc_fsm.sv
module vbc_fsm
  import vbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hdr_valid,
  input  logic        vl_done,
  input  logic        tbl_done,
  input  logic        trap,
  input  logic        blk_exit,
  input  logic        reg_ld,
  input  logic [ST_W-1:0] reg_status,
  output vbc_status_e status,
  output logic        hdr_go
);

  vbc_status_e st_q;
  vbc_status_e st_d;
  logic        st_en;

  assign hdr_go = (st_q == ST_SCALAR) && hdr_valid && !blk_exit && !reg_ld;

  always_comb begin
    st_d  = st_q;
    st_en = 1'b0;
    if (blk_exit) begin
      st_d  = ST_SCALAR;
      st_en = 1'b1;
    end else if (reg_ld) begin
      st_d  = vbc_status_e'(reg_status);
      st_en = 1'b1;
    end else begin
      unique case (st_q)
        ST_SCALAR: if (hdr_valid) begin st_d = ST_HDR;   st_en = 1'b1; end
        ST_HDR:    if (vl_done)   begin st_d = ST_TBL;   st_en = 1'b1; end
        ST_TBL:    if (tbl_done)  begin st_d = ST_READY; st_en = 1'b1; end
        ST_READY:  if (trap)      begin st_d = ST_TBL;   st_en = 1'b1; end
        default:   begin st_d = ST_SCALAR; st_en = 1'b1; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_SCALAR;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign status = st_q;

  // R2: header is taken only out of the scalar state
  assert_hdr_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_go |=> (st_q == ST_HDR));

  // R4: length setup completion advances to table loading
  assert_tbl_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HDR && vl_done && !blk_exit && !reg_ld) |=> (st_q == ST_TBL));

  // R5: a trap after table load rewinds to the loading phase
  assert_trap_rewind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_READY && trap && !blk_exit && !reg_ld) |=> (st_q == ST_TBL));

  // R10: a register write sets status regardless of progress pulses
  assert_reg_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_ld && !blk_exit) |=> (st_q == $past(reg_status)));

endmodule

// File: rtl/vbc_immchk.sv
module vbc_immchk
  import vbc_pkg::*;
#(
  parameter int unsigned OFS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             imm_we,
  input  logic             blk_exit,
  input  vbc_status_e      status,
  input  logic [OFS_W-1:0] imm_val,
  input  logic [OFS_W:0]   limit,
  output logic             accept,
  output logic             jump_q,
  output logic             illegal_q
);

  logic in_range;
  logic live;
  logic reject;
  logic jump_d;
  logic ill_d;

  assign in_range = ({1'b0, imm_val} < limit);
  assign live     = imm_we && !blk_exit;
  assign accept   = live && (status == ST_READY) && in_range;
  assign reject   = live && !((status == ST_READY) && in_range);

  always_comb begin
    jump_d = accept;
    ill_d  = reject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jump_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      jump_q    <= jump_d;
      illegal_q <= ill_d;
    end
  end

  // R7: the two flags never coincide
  assert_flag_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(jump_q && illegal_q));

  // R7: an immediate write outside the loaded state is illegal
  assert_notready_ill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_we && !blk_exit && status != ST_READY) |=> illegal_q);

  // R6: a jump is only granted from the loaded state
  assert_jump_needs_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    jump_q |-> ($past(status) == ST_READY));

endmodule

// File: rtl/vbc_fields.sv
module vbc_fields
  import vbc_pkg::*;
#(
  parameter int unsigned OFS_W = 5,
  parameter int unsigned H2_W  = 16,
  localparam int unsigned FLD_W = 1 + ILEN_W + PLEN_W + RLEN_W + 1 + H2_W + OFS_W,
  localparam int unsigned HDR_W = HDR1_W + H2_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             reg_ld,
  input  logic [FLD_W-1:0] reg_val,
  input  logic             hdr_go,
  input  logic [HDR_W-1:0] hdr_word,
  input  logic             ofs_ld,
  input  logic [OFS_W-1:0] ofs_val,
  output logic [FLD_W-1:0] fld_q
);

  localparam int unsigned H2_LSB = OFS_W;

  logic              vlset_q, vlset_d;
  logic [ILEN_W-1:0] ilen_q, ilen_d;
  logic [PLEN_W-1:0] plen_q, plen_d;
  logic [RLEN_W-1:0] rlen_q, rlen_d;
  logic              mode_q, mode_d;
  logic [H2_W-1:0]   h2_q, h2_d;
  logic [OFS_W-1:0]  ofs_q, ofs_d;
  logic              ctx_en;
  logic              ofs_en;

  logic [ILEN_W-1:0] hdr_ilen;
  assign hdr_ilen = hdr_word[3:1];

  always_comb begin
    vlset_d = vlset_q;
    ilen_d  = ilen_q;
    plen_d  = plen_q;
    rlen_d  = rlen_q;
    mode_d  = mode_q;
    h2_d    = h2_q;
    ofs_d   = ofs_q;
    ctx_en  = 1'b0;
    ofs_en  = 1'b0;
    if (clr) begin
      {vlset_d, ilen_d, plen_d, rlen_d, mode_d, h2_d, ofs_d} = '0;
      ctx_en = 1'b1;
      ofs_en = 1'b1;
    end else if (reg_ld) begin
      {vlset_d, ilen_d, plen_d, rlen_d, mode_d, h2_d, ofs_d} = reg_val;
      ctx_en = 1'b1;
      ofs_en = 1'b1;
    end else if (hdr_go) begin
      vlset_d = hdr_word[0];
      ilen_d  = hdr_ilen;
      plen_d  = hdr_word[5:4];
      rlen_d  = hdr_word[7:6];
      mode_d  = hdr_word[8];
      h2_d    = (hdr_ilen == ILEN_EXT) ? hdr_word[HDR1_W +: H2_W] : '0;
      ofs_d   = '0;
      ctx_en  = 1'b1;
      ofs_en  = 1'b1;
    end else if (ofs_ld) begin
      ofs_d  = ofs_val;
      ofs_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vlset_q <= 1'b0;
      ilen_q  <= '0;
      plen_q  <= '0;
      rlen_q  <= '0;
      mode_q  <= 1'b0;
      h2_q    <= '0;
    end else if (ctx_en) begin
      vlset_q <= vlset_d;
      ilen_q  <= ilen_d;
      plen_q  <= plen_d;
      rlen_q  <= rlen_d;
      mode_q  <= mode_d;
      h2_q    <= h2_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
    end else if (ofs_en) begin
      ofs_q <= ofs_d;
    end
  end

  assign fld_q = {vlset_q, ilen_q, plen_q, rlen_q, mode_q, h2_q, ofs_q};

  // R3: a short header leaves the second-header field empty
  assert_h2_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_go && !clr && !reg_ld && hdr_ilen != ILEN_EXT) |=> (fld_q[H2_LSB +: H2_W] == '0));

  // R2: header capture resets the offset pointer
  assert_hdr_ofs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_go && !clr && !reg_ld) |=> (fld_q[OFS_W-1:0] == '0));

endmodule

// File: rtl/vbc_top.sv
module vbc_top
  import vbc_pkg::*;
#(
  parameter int unsigned OFS_W = 5,
  parameter int unsigned H2_W  = 16,
  localparam int unsigned FLD_W = 1 + ILEN_W + PLEN_W + RLEN_W + 1 + H2_W + OFS_W,
  localparam int unsigned REG_W = ST_W + FLD_W,
  localparam int unsigned HDR_W = HDR1_W + H2_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_valid,
  input  logic [HDR_W-1:0] hdr_word,
  input  logic             vl_done,
  input  logic             tbl_done,
  input  logic             trap,
  input  logic             blk_exit,
  input  logic             csr_we,
  input  logic             csr_imm,
  input  logic [REG_W-1:0] csr_wdata,
  input  logic [OFS_W:0]   blk_limit,
  output logic [REG_W-1:0] ctx_reg,
  output logic             jump_req,
  output logic [OFS_W-1:0] jump_ofs,
  output logic             illegal
);

  localparam int unsigned ST_LSB = FLD_W;

  vbc_status_e      status;
  logic             hdr_go;
  logic             reg_ld;
  logic             imm_we;
  logic             accept;
  logic [FLD_W-1:0] fld_q;

  assign reg_ld = csr_we && !csr_imm;
  assign imm_we = csr_we && csr_imm;

  vbc_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdr_valid  (hdr_valid),
    .vl_done    (vl_done),
    .tbl_done   (tbl_done),
    .trap       (trap),
    .blk_exit   (blk_exit),
    .reg_ld     (reg_ld),
    .reg_status (csr_wdata[ST_LSB +: ST_W]),
    .status     (status),
    .hdr_go     (hdr_go)
  );

  vbc_immchk #(.OFS_W(OFS_W)) u_immchk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imm_we    (imm_we),
    .blk_exit  (blk_exit),
    .status    (status),
    .imm_val   (csr_wdata[OFS_W-1:0]),
    .limit     (blk_limit),
    .accept    (accept),
    .jump_q    (jump_req),
    .illegal_q (illegal)
  );

  vbc_fields #(.OFS_W(OFS_W), .H2_W(H2_W)) u_fields (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (blk_exit),
    .reg_ld   (reg_ld),
    .reg_val  (csr_wdata[FLD_W-1:0]),
    .hdr_go   (hdr_go),
    .hdr_word (hdr_word),
    .ofs_ld   (accept),
    .ofs_val  (csr_wdata[OFS_W-1:0]),
    .fld_q    (fld_q)
  );

  assign ctx_reg  = {status, fld_q};
  assign jump_ofs = fld_q[OFS_W-1:0];

  // R9: block exit wipes the word and both flags
  assert_exit_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blk_exit |=> (ctx_reg == '0 && !jump_req && !illegal));

  // R8: a register write is taken whole and raises no flag
  assert_reg_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_ld && !blk_exit) |=> (ctx_reg == $past(csr_wdata) && !jump_req && !illegal));

  // R6: an accepted offset is what the jump targets
  assert_jump_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    jump_req |-> (jump_ofs == $past(csr_wdata[OFS_W-1:0])));

endmodule

// File: tb/vbc_top_test.sv
`timescale 1ns/1ps
module vbc_top_test;

  logic        clk;
  logic        rst_n;
  logic        hdr_valid;
  logic [31:0] hdr_word;
  logic        vl_done, tbl_done, trap, blk_exit;
  logic        csr_we, csr_imm;
  logic [31:0] csr_wdata;
  logic [5:0]  blk_limit;
  logic [31:0] ctx_reg;
  logic        jump_req, illegal;
  logic [4:0]  jump_ofs;

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_ctx = '0;
  logic        exp_j = 1'b0;
  logic        exp_i = 1'b0;

  vbc_top uut (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_word(hdr_word),
    .vl_done(vl_done), .tbl_done(tbl_done), .trap(trap), .blk_exit(blk_exit),
    .csr_we(csr_we), .csr_imm(csr_imm), .csr_wdata(csr_wdata),
    .blk_limit(blk_limit), .ctx_reg(ctx_reg), .jump_req(jump_req),
    .jump_ofs(jump_ofs), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // next {jump, illegal, word} from the current word and inputs
  function automatic logic [33:0] model();
    logic [31:0] n;
    logic j, i;
    logic [1:0] st;
    n = exp_ctx; j = 1'b0; i = 1'b0; st = exp_ctx[31:30];
    if (blk_exit) n = '0;
    else if (csr_we && !csr_imm) n = csr_wdata;
    else begin
      case (st)
        2'd0: if (hdr_valid) begin
          n[31:30] = 2'd1; n[29] = hdr_word[0]; n[28:26] = hdr_word[3:1];
          n[25:24] = hdr_word[5:4]; n[23:22] = hdr_word[7:6]; n[21] = hdr_word[8];
          n[20:5] = (hdr_word[3:1] == 3'b111) ? hdr_word[31:16] : 16'h0;
          n[4:0] = 5'd0;
        end
        2'd1: if (vl_done) n[31:30] = 2'd2;
        2'd2: if (tbl_done) n[31:30] = 2'd3;
        default: if (trap) n[31:30] = 2'd2;
      endcase
      if (csr_we && csr_imm) begin
        if (st == 2'd3 && {1'b0, csr_wdata[4:0]} < blk_limit) begin
          n[4:0] = csr_wdata[4:0]; j = 1'b1;
        end else i = 1'b1;
      end
    end
    return {j, i, n};
  endfunction

  task automatic idle();
    hdr_valid = 0; hdr_word = '0; vl_done = 0; tbl_done = 0; trap = 0;
    blk_exit = 0; csr_we = 0; csr_imm = 0; csr_wdata = '0;
  endtask

  task automatic check(input string tag);
    logic [38:0] act, exp;
    act = {jump_req, illegal, jump_ofs, ctx_reg};
    exp = {exp_j, exp_i, exp_ctx[4:0], exp_ctx};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [33:0] e;
    e = model();
    @(posedge clk);
    @(negedge clk);
    exp_ctx = e[31:0]; exp_j = e[33]; exp_i = e[32];
    check(tag);
    idle();
  endtask

  task automatic to_ready();
    blk_exit = 1; step("R9");
    hdr_valid = 1; hdr_word = 32'hABCD_01FE; step("R2");
    vl_done = 1; step("R4");
    tbl_done = 1; step("R4");
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    string tg;
    rst_n = 0; idle(); blk_limit = 6'd16;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1;
    @(negedge clk);
    check("R1");

    // R4: progress pulses ignored while scalar
    vl_done = 1; tbl_done = 1; trap = 1; step("R4");
    // R2 and R3: long header
    hdr_valid = 1; hdr_word = 32'h5A5A_016F; step("R3");
    // R2: hdr_valid ignored outside scalar
    hdr_valid = 1; hdr_word = 32'hFFFF_FFFF; step("R2");
    // R5: trap ignored while header captured
    trap = 1; step("R5");
    // R7: immediate write while not loaded
    csr_we = 1; csr_imm = 1; csr_wdata = 32'd3; step("R7");
    vl_done = 1; step("R4");
    tbl_done = 1; step("R4");
    // R6: edge of range
    csr_we = 1; csr_imm = 1; csr_wdata = 32'd15; step("R6");
    csr_we = 1; csr_imm = 1; csr_wdata = 32'd16; step("R7");
    blk_limit = 6'd32;
    csr_we = 1; csr_imm = 1; csr_wdata = 32'd31; step("R6");
    blk_limit = 6'd0;
    csr_we = 1; csr_imm = 1; csr_wdata = 32'd0; step("R7");
    blk_limit = 6'd16;
    // R5: trap from loaded
    trap = 1; step("R5");
    // R9: exit beats register write
    blk_exit = 1; csr_we = 1; csr_wdata = 32'hFFFF_FFFF; step("R9");
    // R3: short header drops second header
    hdr_valid = 1; hdr_word = 32'h1234_0035; step("R3");
    // R10: register write beats vl_done
    vl_done = 1; csr_we = 1; csr_wdata = 32'h4000_0123; step("R10");
    // R8: full load including status
    csr_we = 1; csr_wdata = 32'hDEAD_BEEF; step("R8");
    to_ready();
    csr_we = 1; csr_imm = 1; csr_wdata = 32'd7; blk_exit = 1; step("R9");

    for (int k = 0; k < 4000; k++) begin
      hdr_valid = ($urandom % 4) == 0;
      hdr_word  = $urandom;
      vl_done   = ($urandom % 4) == 0;
      tbl_done  = ($urandom % 4) == 0;
      trap      = ($urandom % 8) == 0;
      blk_exit  = ($urandom % 24) == 0;
      csr_we    = ($urandom % 3) == 0;
      csr_imm   = ($urandom % 8) != 0;
      csr_wdata = $urandom;
      blk_limit = 6'($urandom % 33);
      if (blk_exit) tg = "R9";
      else if (csr_we && !csr_imm) tg = "R8";
      else if (csr_we) tg = "R6";
      else tg = "R4";
      step(tg);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule